// File: doc/BRIEF.md
# Trapping Execution ALU with Persistent Carry

This block is the arithmetic and logic unit of an execution pipeline stage. It combines two 32-bit operands with one of twelve operations: signed, unsigned, tag-checked and carry-free add or subtract, three bitwise operations, and an unsigned bounds comparison. A one-bit carry register persists across operations. It feeds the signed and unsigned add and subtract as their carry-in, and each operation defines what is written back into it.

Alongside the operation, the caller picks one of thirteen trap conditions. The condition is evaluated on the result and on the operation's side flags (overflow, bounds, tag error). When the condition holds, the block outputs the condition's own code as a trap code in place of the no-fault code 0, and the carry register keeps its old value. The result and the trap code are combinational on the inputs and the current carry. The carry register changes only on a clock edge where the operation strobe is high and no trap is reported. Dispatching the trap is left to surrounding logic.

Top module: `trap_alu`

## Requirements
- R1: With rst_n low at a rising clock edge (synchronous, active low), the carry register (carry_q) becomes 0.
- R2: Unsigned add (op_sel 1) gives result = A + B + carry_q, and the carry-out of that 32-bit sum becomes the next carry.
- R3: Unsigned subtract (op_sel 3) gives result = A + ~B + ~carry_q, and the inverted adder carry-out (a borrow) becomes the next carry.
- R4: Signed add (op_sel 0) computes A + B + carry_q. Signed subtract (op_sel 2) computes A + ~B + ~carry_q. Overflow is set for sign patterns (a,b,r) = (0,0,1) or (1,1,0) on add, and (0,1,1) or (1,0,0) on subtract. Both operations write 0 into the carry.
- R5: Tagged add (op_sel 4) and tagged subtract (op_sel 5) compute A + B and A - B without using the carry. A tag error is flagged unless the top three bits of A, of B and of the result are each all equal. Both operations write 0 into the carry.
- R6: Plain add (op_sel 6) and plain subtract (op_sel 7) compute A + B and A - B without using the carry, and leave the carry unchanged.
- R7: Bounds check (op_sel 11) outputs A unchanged. It sets the bounds flag when the carry-out of A + ~B + 1 is 1 (A >= B unsigned), and it leaves the carry unchanged.
- R8: AND (op_sel 8), OR (op_sel 9) and XOR (op_sel 10) never report a trap, whatever the condition, and leave the carry unchanged.
- R9: Condition codes on cond_sel: 0 never, 1 result zero, 2 result negative, 3 result <= 0, 4 always, 5 result >= 0, 6 result > 0, 7 overflow, 8 no overflow, 9 bounds, 10 no bounds, 11 tag error, 12 no tag error. Signs are two's complement. When the selected condition holds, trap_code equals cond_sel and trap_hit is 1. Otherwise trap_code is 0 and trap_hit is 0.
- R10: The carry register is written only at a rising edge where op_valid is 1 and trap_hit is 0. Otherwise it holds its value.
- R11: Reserved condition codes 13 to 15 never trap. Reserved operations 12 to 15 give result 0, never trap and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe; enables the carry update |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_sel | input | 4 | Operation code |
| cond_sel | input | 4 | Trap condition selector |
| result | output | 32 | Operation result (combinational) |
| trap_code | output | 4 | Selected condition code when it holds, else 0 |
| trap_hit | output | 1 | Selected condition holds |
| carry_q | output | 1 | Carry register |

## Verification
The result, trap_code and trap_hit depend only on the present inputs and carry_q, so they are due in the cycle the operands are driven. The bench drives at the falling edge and samples one nanosecond later, before the next rising edge. The carry effect is due one rising edge later. It is sampled two nanoseconds after that edge, once the strobe has been dropped, so no further update can mask it. Before each table vector, the carry-in it needs is set up with its own operation, so every vector starts from a known carry.

// File: rtl/alu_pkg.sv
// Shared encodings for the trapping ALU.
// Assumes 4-bit operation and condition selectors; code 0 of the
// condition set doubles as the no-fault trap code.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_SADD = 4'd0,
        OP_UADD = 4'd1,
        OP_SSUB = 4'd2,
        OP_USUB = 4'd3,
        OP_TADD = 4'd4,
        OP_TSUB = 4'd5,
        OP_PADD = 4'd6,
        OP_PSUB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_BND  = 4'd11
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_NEVER  = 4'd0,
        CC_ZERO   = 4'd1,
        CC_NEG    = 4'd2,
        CC_LEZ    = 4'd3,
        CC_ALWAYS = 4'd4,
        CC_GEZ    = 4'd5,
        CC_POS    = 4'd6,
        CC_OVF    = 4'd7,
        CC_NOVF   = 4'd8,
        CC_BND    = 4'd9,
        CC_NBND   = 4'd10,
        CC_TAG    = 4'd11,
        CC_NTAG   = 4'd12
    } alu_cond_e;

    localparam logic [3:0] NO_FAULT = 4'd0;

endpackage

// File: rtl/alu_tag_chk.sv
// Tag uniformity checker: reports whether the top TAG_BITS bits of a
// word are all equal. Assumes 1 <= TAG_BITS <= W.
module alu_tag_chk #(
    parameter int W        = 32,
    parameter int TAG_BITS = 3
) (
    input  logic [W-1:0] word_in,
    output logic         uniform
);
    localparam int NPAIR = (TAG_BITS > 1) ? TAG_BITS - 1 : 1;

    logic [NPAIR-1:0] diff;

    generate
        if (TAG_BITS > 1) begin : g_multi
            for (genvar i = 0; i < TAG_BITS - 1; i++) begin : g_pair
                // Adjacent tag bits differ
                assign diff[i] = word_in[W-1-i] ^ word_in[W-2-i];
            end
        end else begin : g_single
            // A single tag bit is trivially uniform
            assign diff = '0;
        end
    endgenerate

    // Uniform when no adjacent pair differs
    assign uniform = ~|diff;

endmodule

// File: rtl/alu_datapath.sv
// ALU datapath: one shared adder serves every add, subtract and bounds
// operation; the bitwise operations sit beside it. Produces the result,
// the carry value to store, the side flags and whether conditions are
// evaluated. Assumes cin is the current carry register.
module alu_datapath
    import alu_pkg::*;
#(
    parameter int W        = 32,
    parameter int TAG_BITS = 3
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         carry_nxt,
    output logic         ovf,
    output logic         bnd,
    output logic         tag_err,
    output logic         cond_en
);
    localparam int NCHK = 3;

    logic         inv_b;
    logic         add_ci;
    logic [W-1:0] add_y;
    logic [W:0]   add_full;
    logic [W-1:0] sum;
    logic         cout;
    logic         sa, sb, sr;
    logic [W-1:0] chk_word [NCHK];
    logic [NCHK-1:0] chk_ok;
    alu_op_e      op_e;

    assign op_e = alu_op_e'(op);

    // Select adder operand inversion and carry-in per operation
    always_comb begin
        inv_b  = 1'b0;
        add_ci = 1'b0;
        unique case (op_e)
            OP_SADD, OP_UADD: begin inv_b = 1'b0; add_ci = cin;  end
            OP_SSUB, OP_USUB: begin inv_b = 1'b1; add_ci = ~cin; end
            OP_TADD, OP_PADD: begin inv_b = 1'b0; add_ci = 1'b0; end
            OP_TSUB, OP_PSUB,
            OP_BND:           begin inv_b = 1'b1; add_ci = 1'b1; end
            default:          begin inv_b = 1'b0; add_ci = 1'b0; end
        endcase
    end

    // Shared adder
    assign add_y    = inv_b ? ~b : b;
    assign add_full = {1'b0, a} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
    assign sum      = add_full[W-1:0];
    assign cout     = add_full[W];

    assign sa = a[W-1];
    assign sb = b[W-1];
    assign sr = sum[W-1];

    // Tag checks on A, B and the sum
    assign chk_word[0] = a;
    assign chk_word[1] = b;
    assign chk_word[2] = sum;

    generate
        for (genvar g = 0; g < NCHK; g++) begin : g_tag
            alu_tag_chk #(.W(W), .TAG_BITS(TAG_BITS)) i_chk (
                .word_in (chk_word[g]),
                .uniform (chk_ok[g])
            );
        end
    endgenerate

    // Result, flags and carry write-back value per operation
    always_comb begin
        res       = '0;
        carry_nxt = cin;
        ovf       = 1'b0;
        bnd       = 1'b0;
        tag_err   = 1'b0;
        cond_en   = 1'b1;
        unique case (op_e)
            OP_SADD: begin
                res       = sum;
                ovf       = (sa == sb) && (sr != sa);
                carry_nxt = 1'b0;
            end
            OP_SSUB: begin
                res       = sum;
                ovf       = (sa != sb) && (sr != sa);
                carry_nxt = 1'b0;
            end
            OP_UADD: begin
                res       = sum;
                carry_nxt = cout;
            end
            OP_USUB: begin
                res       = sum;
                carry_nxt = ~cout;
            end
            OP_TADD, OP_TSUB: begin
                res       = sum;
                tag_err   = ~&chk_ok;
                carry_nxt = 1'b0;
            end
            OP_PADD, OP_PSUB: begin
                res       = sum;
            end
            OP_BND: begin
                res       = a;
                bnd       = cout;
            end
            OP_AND: begin
                res     = a & b;
                cond_en = 1'b0;
            end
            OP_OR: begin
                res     = a | b;
                cond_en = 1'b0;
            end
            OP_XOR: begin
                res     = a ^ b;
                cond_en = 1'b0;
            end
            default: begin
                res     = '0;
                cond_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_cond.sv
// Trap condition evaluator: tests the selected condition against the
// result and side flags and emits the condition code when it holds.
// Assumes results are two's complement; reserved codes never trap.
module alu_cond
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   cond,
    input  logic         enable,
    input  logic [W-1:0] res,
    input  logic         ovf,
    input  logic         bnd,
    input  logic         tag_err,
    output logic         hit,
    output logic [3:0]   code
);
    logic      is_zero;
    logic      is_neg;
    logic      holds;
    alu_cond_e cond_e;

    assign cond_e  = alu_cond_e'(cond);
    assign is_zero = (res == '0);
    assign is_neg  = res[W-1];

    // Decide whether the selected condition is true
    always_comb begin
        unique case (cond_e)
            CC_NEVER:  holds = 1'b0;
            CC_ZERO:   holds = is_zero;
            CC_NEG:    holds = is_neg;
            CC_LEZ:    holds = is_neg | is_zero;
            CC_ALWAYS: holds = 1'b1;
            CC_GEZ:    holds = ~is_neg;
            CC_POS:    holds = ~is_neg & ~is_zero;
            CC_OVF:    holds = ovf;
            CC_NOVF:   holds = ~ovf;
            CC_BND:    holds = bnd;
            CC_NBND:   holds = ~bnd;
            CC_TAG:    holds = tag_err;
            CC_NTAG:   holds = ~tag_err;
            default:   holds = 1'b0;
        endcase
    end

    // Gate by operation class and form the trap code
    assign hit  = enable & holds;
    assign code = hit ? cond : NO_FAULT;

endmodule

// File: rtl/trap_alu.sv
// Trapping ALU top: datapath, condition evaluator and the persistent
// carry register. Result and trap outputs are combinational; the carry
// is written on a strobed, non-trapping clock edge.
// Assumes a synchronous active-low reset.
module trap_alu
    import alu_pkg::*;
#(
    parameter int W        = 32,
    parameter int TAG_BITS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    input  logic [3:0]   cond_sel,
    output logic [W-1:0] result,
    output logic [3:0]   trap_code,
    output logic         trap_hit,
    output logic         carry_q
);
    logic carry_nxt;
    logic ovf, bnd, tag_err, cond_en;

    alu_datapath #(.W(W), .TAG_BITS(TAG_BITS)) i_dp (
        .op        (op_sel),
        .a         (op_a),
        .b         (op_b),
        .cin       (carry_q),
        .res       (result),
        .carry_nxt (carry_nxt),
        .ovf       (ovf),
        .bnd       (bnd),
        .tag_err   (tag_err),
        .cond_en   (cond_en)
    );

    alu_cond #(.W(W)) i_cond (
        .cond    (cond_sel),
        .enable  (cond_en),
        .res     (result),
        .ovf     (ovf),
        .bnd     (bnd),
        .tag_err (tag_err),
        .hit     (trap_hit),
        .code    (trap_code)
    );

    // Carry register: cleared on reset, written on a strobed non-trapping op
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (op_valid && !trap_hit)
            carry_q <= carry_nxt;
    end

    // R1: reset clears the carry on the following edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !carry_q);

    // R10: no strobe, no carry change
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> carry_q == $past(carry_q));

    // R10: a trapping op leaves the carry alone
    a_r10_trap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && trap_hit) |=> carry_q == $past(carry_q));

    // R9: trap flag and trap code agree
    a_r9_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trap_hit == (trap_code != NO_FAULT));

    // R8: bitwise ops never trap
    a_r8_logic_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) |-> !trap_hit);

    // R7: bounds check passes A through
    a_r7_bnd_passes_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_BND) |-> result == op_a);

    // R6: plain add/subtract leaves the carry unchanged
    a_r6_plain_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_PADD || op_sel == OP_PSUB)) |=> carry_q == $past(carry_q));

endmodule

// File: tb/test_trap_alu.sv
module test_trap_alu;

    typedef struct packed {
        logic [3:0]  req;
        logic        cin;
        logic [3:0]  op;
        logic [3:0]  cond;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [3:0]  code;
        logic        cout;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  1'b0, 4'd1,  4'd0,  32'h5,        32'h7,        32'hC,        4'd0,  1'b0},
        '{4'd2,  1'b1, 4'd1,  4'd0,  32'hFFFFFFFF, 32'h0,        32'h0,        4'd0,  1'b1},
        '{4'd10, 1'b0, 4'd1,  4'd1,  32'hFFFFFFFF, 32'h1,        32'h0,        4'd1,  1'b0},
        '{4'd3,  1'b0, 4'd3,  4'd0,  32'h3,        32'h5,        32'hFFFFFFFE, 4'd0,  1'b1},
        '{4'd3,  1'b1, 4'd3,  4'd0,  32'hA,        32'h3,        32'h6,        4'd0,  1'b0},
        '{4'd4,  1'b0, 4'd0,  4'd7,  32'h7FFFFFFF, 32'h1,        32'h80000000, 4'd7,  1'b0},
        '{4'd4,  1'b1, 4'd0,  4'd8,  32'h1,        32'h2,        32'h4,        4'd8,  1'b1},
        '{4'd4,  1'b1, 4'd0,  4'd0,  32'h1,        32'h1,        32'h3,        4'd0,  1'b0},
        '{4'd4,  1'b0, 4'd2,  4'd7,  32'h80000000, 32'h1,        32'h7FFFFFFF, 4'd7,  1'b0},
        '{4'd4,  1'b1, 4'd2,  4'd2,  32'h5,        32'h5,        32'hFFFFFFFF, 4'd2,  1'b1},
        '{4'd5,  1'b1, 4'd4,  4'd11, 32'h1,        32'h2,        32'h3,        4'd0,  1'b0},
        '{4'd5,  1'b0, 4'd4,  4'd11, 32'h1FFFFFFF, 32'h1,        32'h20000000, 4'd11, 1'b0},
        '{4'd5,  1'b1, 4'd5,  4'd12, 32'h0,        32'h1,        32'hFFFFFFFF, 4'd12, 1'b1},
        '{4'd6,  1'b1, 4'd6,  4'd0,  32'hFFFFFFFF, 32'h2,        32'h1,        4'd0,  1'b1},
        '{4'd6,  1'b0, 4'd7,  4'd5,  32'h2,        32'h5,        32'hFFFFFFFD, 4'd0,  1'b0},
        '{4'd7,  1'b1, 4'd11, 4'd9,  32'h3,        32'h9,        32'h3,        4'd0,  1'b1},
        '{4'd7,  1'b0, 4'd11, 4'd10, 32'h3,        32'h9,        32'h3,        4'd10, 1'b0},
        '{4'd7,  1'b0, 4'd11, 4'd9,  32'h9,        32'h9,        32'h9,        4'd9,  1'b0},
        '{4'd8,  1'b1, 4'd8,  4'd4,  32'hF0F0,     32'hFF00,     32'hF000,     4'd0,  1'b1},
        '{4'd8,  1'b0, 4'd9,  4'd4,  32'hF0,       32'h0F,       32'hFF,       4'd0,  1'b0},
        '{4'd8,  1'b1, 4'd10, 4'd1,  32'hAA,       32'hAA,       32'h0,        4'd0,  1'b1},
        '{4'd9,  1'b0, 4'd1,  4'd4,  32'h1,        32'h1,        32'h2,        4'd4,  1'b0},
        '{4'd9,  1'b1, 4'd1,  4'd6,  32'h0,        32'h0,        32'h1,        4'd6,  1'b1},
        '{4'd9,  1'b0, 4'd6,  4'd3,  32'h0,        32'h0,        32'h0,        4'd3,  1'b0},
        '{4'd11, 1'b0, 4'd1,  4'd13, 32'hFFFFFFFF, 32'h1,        32'h0,        4'd0,  1'b1},
        '{4'd11, 1'b1, 4'd12, 4'd4,  32'h5,        32'h5,        32'h0,        4'd0,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  op_sel = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] result;
    logic [3:0]  trap_code;
    logic        trap_hit;
    logic        carry_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_alu i_trap_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .cond_sel  (cond_sel),
        .result    (result),
        .trap_code (trap_code),
        .trap_hit  (trap_hit),
        .carry_q   (carry_q)
    );

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One strobed operation; leaves op_valid low after the edge
    task automatic run_op(input logic [3:0] op, input logic [3:0] cc,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op; cond_sel = cc; op_a = a; op_b = b; op_valid = 1'b1;
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    task automatic set_carry(input logic c);
        if (c) run_op(4'd1, 4'd0, 32'hFFFFFFFF, 32'h1);
        else   run_op(4'd4, 4'd0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "carry after reset", {31'b0, carry_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            set_carry(VECS[i].cin);
            @(negedge clk);
            op_sel = VECS[i].op; cond_sel = VECS[i].cond;
            op_a = VECS[i].a; op_b = VECS[i].b; op_valid = 1'b1;
            #1;
            check(tag(VECS[i].req), "result", result, VECS[i].res);
            check(tag(VECS[i].req), "trap_code", {28'b0, trap_code}, {28'b0, VECS[i].code});
            @(posedge clk);
            #1 op_valid = 1'b0;
            #1;
            check(tag(VECS[i].req), "carry", {31'b0, carry_q}, {31'b0, VECS[i].cout});
        end

        // R10: an unstrobed carry-producing add must not write the carry
        set_carry(1'b0);
        @(negedge clk);
        op_sel = 4'd1; cond_sel = 4'd0; op_a = 32'hFFFFFFFF; op_b = 32'h1; op_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R10", "carry with strobe low", {31'b0, carry_q}, 32'h0);

        // R9: trap flag follows the code (negative condition on a positive result)
        @(negedge clk);
        op_sel = 4'd6; cond_sel = 4'd2; op_a = 32'h1; op_b = 32'h1;
        #1;
        check("R9", "trap_hit false", {31'b0, trap_hit}, 32'h0);
        cond_sel = 4'd6;
        #1;
        check("R9", "trap_hit true", {31'b0, trap_hit}, 32'h1);

        // R1: reset in mid-run clears a set carry
        set_carry(1'b1);
        check("R1", "carry set before reset", {31'b0, carry_q}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "carry after mid-run reset", {31'b0, carry_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule